// File: doc/BRIEF.md
# Dual-Band Tone Frequency Qualifier

This block decides whether the squared-up output of a tone comparator carries a call-charge tone near 12 kHz or near 16 kHz. Each channel takes a one-bit comparator signal, which may change at any time. It resynchronises that signal and measures the number of reference-clock cycles between successive rising edges. It then classifies each measured period as inside or outside the accepted window of the selected band. A shared band input picks the window: 1 selects the 12 kHz system and 0 selects the 16 kHz system. Two channels share the reference clock and the band selection, and otherwise run independently.

For every in-band period, a channel emits a one-cycle strobe. A per-channel qualifier state machine filters these results into a tone-present flag for downstream output-format logic. The state machine has four states: IDLE (no tone), ACQUIRE (counting consecutive in-band periods), PRESENT (tone held) and FADE (tone still held while counting consecutive out-of-band periods). Its named transitions are as follows.
- start: IDLE to ACQUIRE on a good period.
- confirm: ACQUIRE to PRESENT on the N-th consecutive good period.
- abort: ACQUIRE to IDLE on a bad period.
- falter: PRESENT to FADE on a bad period.
- recover: FADE to PRESENT on a good period.
- release: FADE to IDLE on the N-th consecutive bad period.
- drop: any state to IDLE on a no-edge timeout.

The accept limits sit midway between the must-detect and must-not-detect period counts, and the limits are derived from the clock frequency parameter. With the default values (a 3.579545 MHz clock and N = 8), the flag settles in under 1 ms, well inside the 10 ms limit.

Top module: `tone_band_qualifier`

## Requirements
- R1: The comparator input passes through a two-flop synchroniser. A period is the number of clock cycles between two consecutive synchronised rising edges, so a square wave with rising edges P cycles apart measures P.
- R2: With band_12k = 1, a period is in band when 289 <= P <= 306 (default parameters). Periods of 288 and 307 are out of band.
- R3: With band_12k = 0, a period is in band when 217 <= P <= 230 (default parameters). Periods of 216 and 231 are out of band.
- R4: prd_ok[i] pulses high for exactly one cycle for each in-band period measured on channel i. It does not pulse for an out-of-band period, or for the first rising edge after reset or after a timeout, since no period ends on that edge.
- R5: tone_on[i] rises after N_QUAL (8) consecutive in-band periods. It stays low after only N_QUAL-1 of them, and any out-of-band period restarts the run.
- R6: Once tone_on[i] is high, it falls after N_QUAL consecutive out-of-band periods. A shorter run of bad periods followed by a good period leaves it high.
- R7: If TMO_CYC (612 by default, twice the 12 kHz upper limit) cycles pass with no rising edge, tone_on[i] clears. The next edge then starts a new measurement without producing a period.
- R8: The two channels measure and qualify independently. Activity on one channel never changes the other channel's prd_ok or tone_on.
- R9: While rst_n is low, and right after it is released, all prd_ok and tone_on bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (nominal 3.579545 MHz) |
| rst_n | input | 1 | Active-low synchronous reset |
| band_12k | input | 1 | Band select: 1 = 12 kHz system, 0 = 16 kHz system |
| cmp_in | input | NCH | Asynchronous comparator output, one bit per channel |
| prd_ok | output | NCH | One-cycle strobe per in-band period |
| tone_on | output | NCH | Filtered tone-present flag |

## Verification
A period counter that is off by one shows at the ports as a wrong prd_ok count on a square wave that sits exactly on a window limit. The error appears within one period of the second rising edge. A qualifier run counter or state that is wrong shows as tone_on changing one period early or late. The bench therefore drives runs of exactly N_QUAL-1 and N_QUAL periods and samples tone_on one period after the last edge. A stuck timeout shows as tone_on still high after a silence longer than TMO_CYC.

// File: rtl/tbq_pkg.sv
package tbq_pkg;

    typedef enum logic [1:0] {
        Q_IDLE    = 2'd0,
        Q_ACQUIRE = 2'd1,
        Q_PRESENT = 2'd2,
        Q_FADE    = 2'd3
    } qual_state_e;

    // Midpoint between two period counts given as frequencies in Hz.
    function automatic int period_mid(input int clk_hz, input int f_a, input int f_b);
        return ((clk_hz / f_a) + (clk_hz / f_b)) / 2;
    endfunction

endpackage

// File: rtl/tbq_edge_sync.sv
module tbq_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic meta_q;
    logic sync_q;
    logic last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign rise_o = sync_q & ~last_q;

    // R1: a rising edge needs a low sample before it, so edges never touch
    p_edge_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/tbq_period_meter.sv
module tbq_period_meter #(
    parameter int CW     = 10,
    parameter int MIN12  = 289,
    parameter int MAX12  = 306,
    parameter int MIN16  = 217,
    parameter int MAX16  = 230,
    parameter int TMO    = 612
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    input  logic band_12k_i,
    output logic ev_good_o,
    output logic ev_bad_o,
    output logic ev_tmo_o
);
    localparam logic [CW:0]   LO12_V = (CW+1)'(MIN12);
    localparam logic [CW:0]   HI12_V = (CW+1)'(MAX12);
    localparam logic [CW:0]   LO16_V = (CW+1)'(MIN16);
    localparam logic [CW:0]   HI16_V = (CW+1)'(MAX16);
    localparam logic [CW-1:0] TMO_V  = CW'(TMO);
    localparam logic [CW-1:0] TMO_M1 = CW'(TMO - 1);

    logic [CW-1:0] cnt_q;
    logic          armed_q;
    logic [CW:0]   meas;
    logic          in_band;
    logic          tmo_hit;

    always_comb begin
        meas    = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};
        if (band_12k_i) begin
            in_band = (meas >= LO12_V) && (meas <= HI12_V);
        end else begin
            in_band = (meas >= LO16_V) && (meas <= HI16_V);
        end
        tmo_hit = armed_q && !rise_i && (cnt_q == TMO_M1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= TMO_V;
            armed_q   <= 1'b0;
            ev_good_o <= 1'b0;
            ev_bad_o  <= 1'b0;
            ev_tmo_o  <= 1'b0;
        end else begin
            ev_good_o <= rise_i && armed_q && in_band;
            ev_bad_o  <= rise_i && armed_q && !in_band;
            ev_tmo_o  <= tmo_hit;
            if (rise_i) begin
                cnt_q   <= '0;
                armed_q <= 1'b1;
            end else begin
                if (cnt_q != TMO_V) begin
                    cnt_q <= cnt_q + 1'b1;
                end
                if (tmo_hit) begin
                    armed_q <= 1'b0;
                end
            end
        end
    end

    // R7: the since-edge counter never passes the timeout limit
    p_cnt_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TMO_V);
    // R4: an in-band strobe lasts a single cycle
    p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_good_o |=> !ev_good_o);
    // R4: a period is never both good and bad
    p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ev_good_o, ev_bad_o, ev_tmo_o}) <= 1);

endmodule

// File: rtl/tbq_qual_fsm.sv
module tbq_qual_fsm
    import tbq_pkg::*;
#(
    parameter int N_QUAL = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ev_good_i,
    input  logic ev_bad_i,
    input  logic ev_tmo_i,
    output logic tone_o
);
    localparam int RW = $clog2(N_QUAL + 1);

    qual_state_e state_q, state_d;
    logic [RW-1:0] run_q, run_d;
    logic          run_full;

    assign run_full = (int'(run_q) + 1) >= N_QUAL;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= Q_IDLE;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        if (ev_tmo_i) begin
            state_d = Q_IDLE;                 // drop
            run_d   = '0;
        end else begin
            unique case (state_q)
                Q_IDLE, Q_ACQUIRE: begin
                    if (ev_good_i) begin
                        if (run_full) begin
                            state_d = Q_PRESENT;  // confirm
                            run_d   = '0;
                        end else begin
                            state_d = Q_ACQUIRE;  // start / count
                            run_d   = run_q + 1'b1;
                        end
                    end else if (ev_bad_i) begin
                        state_d = Q_IDLE;         // abort
                        run_d   = '0;
                    end
                end
                Q_PRESENT, Q_FADE: begin
                    if (ev_bad_i) begin
                        if (run_full) begin
                            state_d = Q_IDLE;     // release
                            run_d   = '0;
                        end else begin
                            state_d = Q_FADE;     // falter / count
                            run_d   = run_q + 1'b1;
                        end
                    end else if (ev_good_i) begin
                        state_d = Q_PRESENT;      // recover
                        run_d   = '0;
                    end
                end
                default: begin
                    state_d = Q_IDLE;
                    run_d   = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            Q_PRESENT, Q_FADE: tone_o = 1'b1;
            default:           tone_o = 1'b0;
        endcase
    end

    // R5: the flag only rises right after an in-band period
    p_rise_good_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tone_o) |-> $past(ev_good_i));
    // R6: the flag only falls right after a bad period or a timeout
    p_fall_bad_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tone_o) |-> $past(ev_bad_i || ev_tmo_i));
    // R7: a timeout always lands in IDLE
    p_tmo_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tmo_i |=> (state_q == Q_IDLE));
    // R5: the run counter stays below the qualification length
    p_run_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(run_q) < N_QUAL);

endmodule

// File: rtl/tone_band_qualifier.sv
module tone_band_qualifier #(
    parameter int CLK_HZ      = 3579545,
    parameter int NCH         = 2,
    parameter int N_QUAL      = 8,
    parameter int F12_PASS_LO = 11820,
    parameter int F12_PASS_HI = 12180,
    parameter int F12_STOP_LO = 11520,
    parameter int F12_STOP_HI = 12480,
    parameter int F16_PASS_LO = 15760,
    parameter int F16_PASS_HI = 16240,
    parameter int F16_STOP_LO = 15360,
    parameter int F16_STOP_HI = 16640
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           band_12k,
    input  logic [NCH-1:0] cmp_in,
    output logic [NCH-1:0] prd_ok,
    output logic [NCH-1:0] tone_on
);
    localparam int MIN12   = tbq_pkg::period_mid(CLK_HZ, F12_STOP_HI, F12_PASS_HI);
    localparam int MAX12   = tbq_pkg::period_mid(CLK_HZ, F12_PASS_LO, F12_STOP_LO);
    localparam int MIN16   = tbq_pkg::period_mid(CLK_HZ, F16_STOP_HI, F16_PASS_HI);
    localparam int MAX16   = tbq_pkg::period_mid(CLK_HZ, F16_PASS_LO, F16_STOP_LO);
    localparam int TMO_CYC = 2 * ((MAX12 > MAX16) ? MAX12 : MAX16);
    localparam int CW      = $clog2(TMO_CYC + 1);

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic rise;
        logic ev_good;
        logic ev_bad;
        logic ev_tmo;

        tbq_edge_sync u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (cmp_in[g]),
            .rise_o  (rise)
        );

        tbq_period_meter #(
            .CW    (CW),
            .MIN12 (MIN12),
            .MAX12 (MAX12),
            .MIN16 (MIN16),
            .MAX16 (MAX16),
            .TMO   (TMO_CYC)
        ) u_meter (
            .clk        (clk),
            .rst_n      (rst_n),
            .rise_i     (rise),
            .band_12k_i (band_12k),
            .ev_good_o  (ev_good),
            .ev_bad_o   (ev_bad),
            .ev_tmo_o   (ev_tmo)
        );

        tbq_qual_fsm #(
            .N_QUAL (N_QUAL)
        ) u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .ev_good_i (ev_good),
            .ev_bad_i  (ev_bad),
            .ev_tmo_i  (ev_tmo),
            .tone_o    (tone_on[g])
        );

        assign prd_ok[g] = ev_good;

        // R9: nothing is reported in the cycle after reset
        p_reset_quiet_r9: assert property (@(posedge clk)
            !rst_n |=> (!prd_ok[g] && !tone_on[g]));
    end

endmodule

// File: tb/tone_band_qualifier_tb.sv
`timescale 1ns/1ps
module tone_band_qualifier_tb;
    localparam int CLK_HZ = 3579545;
    localparam int NQ     = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       band_12k = 1'b1;
    logic       cmp0 = 1'b0;
    logic       cmp1 = 1'b0;
    logic [1:0] prd_ok;
    logic [1:0] tone_on;
    int         errors = 0;
    int         checks = 0;
    int         sc0 = 0;
    int         sc1 = 0;

    always #5 clk = ~clk;

    tone_band_qualifier u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .band_12k (band_12k),
        .cmp_in   ({cmp1, cmp0}),
        .prd_ok   (prd_ok),
        .tone_on  (tone_on)
    );

    always @(negedge clk) begin
        if (prd_ok[0]) sc0++;
        if (prd_ok[1]) sc1++;
    end

    function automatic int lim_lo(input bit b12);
        return b12 ? ((CLK_HZ/12480 + CLK_HZ/12180) / 2) : ((CLK_HZ/16640 + CLK_HZ/16240) / 2);
    endfunction
    function automatic int lim_hi(input bit b12);
        return b12 ? ((CLK_HZ/11820 + CLK_HZ/11520) / 2) : ((CLK_HZ/15760 + CLK_HZ/15360) / 2);
    endfunction
    function automatic int tmo_cyc();
        return 2 * lim_hi(1'b1);
    endfunction
    function automatic bit good(input bit b12, input int p);
        return (p >= lim_lo(b12)) && (p <= lim_hi(b12));
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cmp(input int ch, input logic v);
        if (ch == 0) cmp0 = v; else cmp1 = v;
    endtask

    // silence, m1 periods of p1, m2 periods of p2, then check tone and strobes
    task automatic run_seq(input int ch, input int p1, input int m1, input int p2, input int m2,
                           input string req);
        int start_cnt;
        int n_good = 0;
        int run = 0;
        bit tone = 0;
        set_cmp(ch, 1'b0);
        repeat (tmo_cyc() + 50) @(negedge clk);
        start_cnt = (ch == 0) ? sc0 : sc1;
        for (int k = 0; k < m1 + m2; k++) begin
            int p = (k < m1) ? p1 : p2;
            set_cmp(ch, 1'b1);
            repeat (p / 2) @(negedge clk);
            set_cmp(ch, 1'b0);
            repeat (p - p / 2) @(negedge clk);
        end
        repeat (2) @(negedge clk);
        for (int k = 1; k < m1 + m2; k++) begin
            int p = (k - 1 < m1) ? p1 : p2;
            bit gd = good(band_12k, p);
            if (gd) n_good++;
            if (!tone) begin
                run = gd ? run + 1 : 0;
                if (run == NQ) begin tone = 1; run = 0; end
            end else begin
                run = gd ? 0 : run + 1;
                if (run == NQ) begin tone = 0; run = 0; end
            end
        end
        check({req, " tone_on"}, int'(tone_on[ch]), int'(tone));
        check({req, " prd_ok count"}, ((ch == 0) ? sc0 : sc1) - start_cnt, n_good);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int s0;
        int s1;
        void'($urandom(32'd7331));
        repeat (4) @(negedge clk);
        check("R9 prd_ok in reset", int'(prd_ok), 0);
        check("R9 tone_on in reset", int'(tone_on), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 tone_on after reset", int'(tone_on), 0);

        // R2 boundaries, R5 qualification length
        band_12k = 1'b1;
        run_seq(0, 289, NQ + 1, 0, 0, "R2 lo edge 289");
        run_seq(0, 306, NQ, 0, 0, "R5 N-1 periods 306");
        run_seq(0, 288, 10, 0, 0, "R2 reject 288");
        run_seq(1, 307, 10, 0, 0, "R2 reject 307");
        // R3 boundaries
        band_12k = 1'b0;
        run_seq(0, 217, 10, 0, 0, "R3 lo edge 217");
        run_seq(1, 230, 10, 0, 0, "R3 hi edge 230");
        run_seq(0, 216, 10, 0, 0, "R3 reject 216");
        run_seq(1, 231, 10, 0, 0, "R3 reject 231");
        // R6 release and hold, R1 exact period on a 12 kHz tone
        band_12k = 1'b1;
        run_seq(0, 300, 10, 250, NQ + 1, "R6 release after N bad");
        run_seq(1, 300, 10, 250, NQ, "R6 hold after N-1 bad");
        run_seq(0, 295, 5, 250, 1, "R5 run restart");
        run_seq(0, 298, NQ + 2, 0, 0, "R1 period measure");

        // R7 timeout clears the flag
        repeat (tmo_cyc() + 20) @(negedge clk);
        check("R7 tone after silence", int'(tone_on[0]), 0);

        // R8 one channel active, the other idle
        s1 = sc1;
        run_seq(0, 300, 12, 0, 0, "R8 active ch0");
        check("R8 idle ch1 tone", int'(tone_on[1]), 0);
        check("R8 idle ch1 strobes", sc1 - s1, 0);

        // random concurrent sequences on both channels
        for (int it = 0; it < 7; it++) begin
            int a1 = 200 + int'($urandom % 140);
            int b1 = 1 + int'($urandom % 14);
            int c1 = 200 + int'($urandom % 140);
            int d1 = int'($urandom % 12);
            int a2 = 200 + int'($urandom % 140);
            int b2 = 1 + int'($urandom % 14);
            int c2 = 200 + int'($urandom % 140);
            int d2 = int'($urandom % 12);
            band_12k = $urandom % 2;
            s0 = sc0;
            fork
                run_seq(0, a1, b1, c1, d1, "R8 random ch0");
                run_seq(1, a2, b2, c2, d2, "R8 random ch1");
            join
            s0 = sc0 - s0;
        end

        repeat (5) @(negedge clk);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule